// File: doc/BRIEF.md
# Interrupt Controller Register Write Path

This block holds the 64-bit state registers of a platform interrupt controller and applies writes to them. The registers are the per-line mask, the trigger-type select, the polarity, the message-enable vector, the pending request vector and a byte-wide vector table. A single write port takes a byte address, a size of 1, 2, 4 or 8 bytes and up to 64 bits of data. Every write lands in one 64-bit register. Only the byte lanes named by the size and the low address bits change; all other bits of that register keep their value.

Writes to the mask register produce per-line unmask and mask event vectors for the delivery logic downstream. Writes to the clear register drop pending requests, but only on lines that are edge-triggered, and they report the dropped lines as an event vector. Pending bits are raised by a per-line request input. Each write is answered one cycle later by an acknowledge. An error flag rides with the acknowledge when the address lies outside the register map.

Top module: `irq_regwrite`

## Requirements
- R1: After reset the mask register is all ones. Trigger select, polarity, message enable, pending and the whole vector table are zero. Acknowledge, error and all three event vectors are zero.
- R2: A write asserts `wr_ack` for exactly one cycle, in the cycle after `wr_en`. `wr_err` is high in that same cycle only when the address is unmapped.
- R3: The lane mask is 0xFF for size 1, 0xFFFF for size 2, 0xFFFF_FFFF for size 4, and all ones for size 8 and for any other size value. Data is truncated to the size and then shifted left together with the mask by 8 × addr[2:0]. Lanes shifted past bit 63 are dropped. The register is chosen by addr with bits [2:0] cleared and becomes (old & ~lanes) | data. The byte offsets are: mask 0x000, trigger select 0x008 (1 = edge, 0 = level), polarity 0x010, message enable 0x018.
- R4: A write to the mask register sets `en_evt` for each line whose mask bit goes 1→0 and `dis_evt` for each line whose mask bit goes 0→1. Both are valid only in the acknowledge cycle and are zero in every other cycle.
- R5: A write to the clear register (0x020) computes pending & trigger-select & shifted data. Those lines are removed from pending and reported on `clr_evt` in the acknowledge cycle. Level-triggered pending bits never change because of a clear write.
- R6: Every cycle, each bit set on `irq_set` becomes a pending bit one cycle later. When a clear write and a request hit the same line in the same cycle, the request wins and the bit stays pending.
- R7: The vector table covers 0x200 to 0x23F, byte k at `vec_q[8k+7:8k]`. A write lands in the 8-byte group at addr[5:3], merged with the same lane mask.
- R8: Writes to 0x030, 0x038 and the range 0x100 to 0x13F are acknowledged without error and change no register.
- R9: A write to any other address raises `wr_err` and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request, one cycle per write |
| wr_addr | input | AW | Byte address of the write |
| wr_size | input | 4 | Write size in bytes (1, 2, 4, 8) |
| wr_data | input | 64 | Write data, right-aligned |
| irq_set | input | 64 | Per-line request that sets pending |
| wr_ack | output | 1 | Write acknowledge |
| wr_err | output | 1 | Unmapped-address error, with acknowledge |
| en_evt | output | 64 | Lines unmasked by the last write |
| dis_evt | output | 64 | Lines masked by the last write |
| clr_evt | output | 64 | Edge lines cleared by the last write |
| mask_q | output | 64 | Mask register |
| trig_q | output | 64 | Trigger select register |
| pol_q | output | 64 | Polarity register |
| msgen_q | output | 64 | Message-enable register |
| pend_q | output | 64 | Pending register |
| vec_q | output | VEC_BYTES*8 | Vector table, flattened |

## Verification
Every register sits directly on a port, so a bad lane mask, shift or select shows up in the cycle after the faulty write. It appears as a wrong value in a neighbouring byte or in the wrong register. Event vectors are compared in that same cycle against mask transitions and cleared lines worked out by hand, which exposes swapped or stale events right away. Ignored and errored writes are checked with a snapshot of every register taken before the write and compared after it.

// File: rtl/irq_regwrite.sv
module irq_regwrite #(
  parameter int AW        = 12,
  parameter int VEC_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [3:0]             wr_size,
  input  logic [63:0]            wr_data,
  input  logic [63:0]            irq_set,
  output logic                   wr_ack,
  output logic                   wr_err,
  output logic [63:0]            en_evt,
  output logic [63:0]            dis_evt,
  output logic [63:0]            clr_evt,
  output logic [63:0]            mask_q,
  output logic [63:0]            trig_q,
  output logic [63:0]            pol_q,
  output logic [63:0]            msgen_q,
  output logic [63:0]            pend_q,
  output logic [VEC_BYTES*8-1:0] vec_q
);

  localparam int GROUPS = VEC_BYTES / 8;
  localparam int WW     = AW - 3;
  localparam logic [WW-1:0] W_MASK  = WW'(32'h000 / 8);
  localparam logic [WW-1:0] W_TRIG  = WW'(32'h008 / 8);
  localparam logic [WW-1:0] W_POL   = WW'(32'h010 / 8);
  localparam logic [WW-1:0] W_MSGEN = WW'(32'h018 / 8);
  localparam logic [WW-1:0] W_CLR   = WW'(32'h020 / 8);
  localparam logic [WW-1:0] W_AUTOA = WW'(32'h030 / 8);
  localparam logic [WW-1:0] W_AUTOB = WW'(32'h038 / 8);
  localparam logic [WW-1:0] W_RT_LO = WW'(32'h100 / 8);
  localparam logic [WW-1:0] W_RT_HI = WW'((32'h100 + 64) / 8);
  localparam logic [WW-1:0] W_VC_LO = WW'(32'h200 / 8);
  localparam logic [WW-1:0] W_VC_HI = WW'((32'h200 + VEC_BYTES) / 8);

  logic [63:0] size_m, lane_m, lane_d, new_mask, clr_lines;
  logic [WW-1:0] widx, vgrp;
  logic sel_mask, sel_trig, sel_pol, sel_msgen, sel_clr, sel_ign, sel_vec, mapped, wr_ok;

  always_comb begin
    case (wr_size)
      4'd1:    size_m = 64'h0000_0000_0000_00FF;
      4'd2:    size_m = 64'h0000_0000_0000_FFFF;
      4'd4:    size_m = 64'h0000_0000_FFFF_FFFF;
      default: size_m = '1;
    endcase
  end

  assign lane_m = size_m << {wr_addr[2:0], 3'b000};
  assign lane_d = (wr_data & size_m) << {wr_addr[2:0], 3'b000};

  assign widx      = wr_addr[AW-1:3];
  assign vgrp      = widx - W_VC_LO;
  assign sel_mask  = widx == W_MASK;
  assign sel_trig  = widx == W_TRIG;
  assign sel_pol   = widx == W_POL;
  assign sel_msgen = widx == W_MSGEN;
  assign sel_clr   = widx == W_CLR;
  assign sel_ign   = widx == W_AUTOA || widx == W_AUTOB || (widx >= W_RT_LO && widx < W_RT_HI);
  assign sel_vec   = widx >= W_VC_LO && widx < W_VC_HI;
  assign mapped    = sel_mask | sel_trig | sel_pol | sel_msgen | sel_clr | sel_ign | sel_vec;
  assign wr_ok     = wr_en & mapped;

  assign new_mask  = (mask_q & ~lane_m) | lane_d;
  assign clr_lines = (wr_ok && sel_clr) ? (pend_q & trig_q & lane_d) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ack  <= 1'b0;
      wr_err  <= 1'b0;
      en_evt  <= '0;
      dis_evt <= '0;
      clr_evt <= '0;
      mask_q  <= '1;
      trig_q  <= '0;
      pol_q   <= '0;
      msgen_q <= '0;
      pend_q  <= '0;
    end else begin
      wr_ack  <= wr_en;
      wr_err  <= wr_en & ~mapped;
      en_evt  <= (wr_ok && sel_mask) ? (mask_q & ~new_mask) : '0;
      dis_evt <= (wr_ok && sel_mask) ? (~mask_q & new_mask) : '0;
      clr_evt <= clr_lines;
      pend_q  <= (pend_q & ~clr_lines) | irq_set;
      if (wr_ok && sel_mask)  mask_q  <= new_mask;
      if (wr_ok && sel_trig)  trig_q  <= (trig_q & ~lane_m) | lane_d;
      if (wr_ok && sel_pol)   pol_q   <= (pol_q & ~lane_m) | lane_d;
      if (wr_ok && sel_msgen) msgen_q <= (msgen_q & ~lane_m) | lane_d;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rst_n)
        vec_q[g*64 +: 64] <= '0;
      else if (wr_ok && sel_vec && vgrp == WW'(g))
        vec_q[g*64 +: 64] <= (vec_q[g*64 +: 64] & ~lane_m) | lane_d;
    end
  end

endmodule

// File: rtl/irq_regwrite_chk.sv
module irq_regwrite_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_ack,
  input logic        wr_err,
  input logic [63:0] en_evt,
  input logic [63:0] dis_evt,
  input logic [63:0] clr_evt,
  input logic [63:0] mask_q,
  input logic [63:0] trig_q,
  input logic [63:0] pol_q,
  input logic [63:0] msgen_q
);

  p_ack_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_ack);

  p_ack_only_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wr_ack);

  p_err_with_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> wr_ack);

  p_events_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ack |-> (en_evt == '0 && dis_evt == '0 && clr_evt == '0));

  p_unmask_leaves_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_evt & mask_q) == '0);

  p_mask_leaves_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_evt & ~mask_q) == '0);

  p_clear_edge_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt & ~trig_q) == '0);

  p_err_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($stable(mask_q) && $stable(trig_q) && $stable(pol_q) && $stable(msgen_q)
                && en_evt == '0 && dis_evt == '0 && clr_evt == '0));

endmodule

bind irq_regwrite irq_regwrite_chk u_chk (.*);

// File: tb/test_irq_regwrite.sv
module test_irq_regwrite;
  localparam int AW = 12;
  localparam int VB = 64;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [3:0] wr_size = '0;
  logic [63:0] wr_data = '0, irq_set = '0;
  logic wr_ack, wr_err;
  logic [63:0] en_evt, dis_evt, clr_evt, mask_q, trig_q, pol_q, msgen_q, pend_q;
  logic [VB*8-1:0] vec_q;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic s_ack, s_err;
  logic [63:0] s_en, s_dis, s_clr;

  always #2 clk = ~clk;

  irq_regwrite #(.AW(AW), .VEC_BYTES(VB)) i_irq_regwrite (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .irq_set(irq_set), .wr_ack(wr_ack), .wr_err(wr_err),
    .en_evt(en_evt), .dis_evt(dis_evt), .clr_evt(clr_evt), .mask_q(mask_q),
    .trig_q(trig_q), .pol_q(pol_q), .msgen_q(msgen_q), .pend_q(pend_q), .vec_q(vec_q));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [3:0] sz, logic [63:0] d, logic [63:0] req = '0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_size = sz; wr_data = d; irq_set = req;
    @(negedge clk);
    wr_en = 1'b0; irq_set = '0;
    s_ack = wr_ack; s_err = wr_err; s_en = en_evt; s_dis = dis_evt; s_clr = clr_evt;
  endtask

  task automatic t_reset();
    chk("R1 mask", mask_q, '1);
    chk("R1 trig", trig_q, '0);
    chk("R1 pol", pol_q, '0);
    chk("R1 msgen", msgen_q, '0);
    chk("R1 pend", pend_q, '0);
    chk("R1 vec", 64'(|vec_q), '0);
    chk("R1 ack/err", {62'd0, wr_ack, wr_err}, '0);
    chk("R1 events", en_evt | dis_evt | clr_evt, '0);
  endtask

  task automatic t_sizes();
    wr(12'h00B, 4'd1, 64'hABCD);
    chk("R2 ack", 64'(s_ack), 64'd1);
    chk("R2 no err", 64'(s_err), 64'd0);
    chk("R3 byte3", trig_q, 64'h0000_0000_CD00_0000);
    @(negedge clk);
    chk("R2 ack one cycle", 64'(wr_ack), 64'd0);
    wr(12'h00E, 4'd2, 64'h1234);
    chk("R3 half at 6", trig_q, 64'h1234_0000_CD00_0000);
    wr(12'h008, 4'd4, 64'hFFFF_FFFF_1122_3344);
    chk("R3 word low", trig_q, 64'h1234_0000_1122_3344);
    wr(12'h010, 4'd8, 64'h0123_4567_89AB_CDEF);
    chk("R3 full", pol_q, 64'h0123_4567_89AB_CDEF);
    wr(12'h010, 4'd3, 64'd0);
    chk("R3 odd size full", pol_q, 64'd0);
    wr(12'h017, 4'd2, 64'hBEEF);
    chk("R3 lane past top", pol_q, 64'hEF00_0000_0000_0000);
    wr(12'h01C, 4'd4, 64'hDEAD_BEEF);
    chk("R3 msgen high word", msgen_q, 64'hDEAD_BEEF_0000_0000);
  endtask

  task automatic t_mask();
    wr(12'h000, 4'd1, 64'h05);
    chk("R4 mask value", mask_q, 64'hFFFF_FFFF_FFFF_FF05);
    chk("R4 unmask evt", s_en, 64'hFA);
    chk("R4 no mask evt", s_dis, 64'd0);
    @(negedge clk);
    chk("R4 events one cycle", en_evt | dis_evt, 64'd0);
    wr(12'h000, 4'd8, 64'hFFFF_FFFF_FFFF_FF0F);
    chk("R4 mask evt", s_dis, 64'h0A);
    chk("R4 no unmask evt", s_en, 64'd0);
  endtask

  task automatic t_clear();
    wr(12'h008, 4'd8, 64'hF0);
    @(negedge clk); irq_set = 64'hFF;
    @(negedge clk); irq_set = '0;
    chk("R6 pending set", pend_q, 64'hFF);
    wr(12'h020, 4'd1, 64'h3C);
    chk("R5 clr evt", s_clr, 64'h30);
    chk("R5 level kept", pend_q, 64'hCF);
    chk("R5 no mask evt", s_en | s_dis, 64'd0);
    wr(12'h020, 4'd1, 64'h40, 64'h40);
    chk("R6 clr evt", s_clr, 64'h40);
    chk("R6 request wins", pend_q, 64'hCF);
  endtask

  task automatic t_vec();
    wr(12'h208, 4'd8, 64'h0807_0605_0403_0201);
    chk("R7 group1", vec_q[127:64], 64'h0807_0605_0403_0201);
    wr(12'h20D, 4'd1, 64'hAA);
    chk("R7 byte13", vec_q[127:64], 64'h0807_AA05_0403_0201);
    wr(12'h23E, 4'd2, 64'h7766);
    chk("R7 last bytes", 64'(vec_q[511:496]), 64'h7766);
    chk("R7 group0 untouched", vec_q[63:0], 64'd0);
  endtask

  task automatic snap_cmp(string tag, logic [AW-1:0] a, bit exp_err);
    logic [63:0] m, t, p, e, q;
    logic [VB*8-1:0] v;
    m = mask_q; t = trig_q; p = pol_q; e = msgen_q; q = pend_q; v = vec_q;
    wr(a, 4'd8, '1);
    chk({tag, " err"}, 64'(s_err), 64'(exp_err));
    chk({tag, " ack"}, 64'(s_ack), 64'd1);
    chk({tag, " regs"}, (mask_q ^ m) | (trig_q ^ t) | (pol_q ^ p) | (msgen_q ^ e) | (pend_q ^ q), 64'd0);
    chk({tag, " vec"}, 64'(|(vec_q ^ v)), 64'd0);
  endtask

  task automatic t_ignored();
    snap_cmp("R8 autoA", 12'h030, 1'b0);
    snap_cmp("R8 autoB", 12'h038, 1'b0);
    snap_cmp("R8 route", 12'h105, 1'b0);
  endtask

  task automatic t_error();
    snap_cmp("R9 0x040", 12'h040, 1'b1);
    snap_cmp("R9 0x140", 12'h140, 1'b1);
    snap_cmp("R9 0x240", 12'h240, 1'b1);
    snap_cmp("R9 0xFF8", 12'hFF8, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_mask();
    t_clear();
    t_vec();
    t_ignored();
    t_error();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule